// File: doc/BRIEF.md
# Linear-count video timing generator

This block produces the sync, data-enable and pixel-colour timing for one video output. It runs two counters off the pixel clock: a horizontal position that wraps every line, and one frame-wide pixel index that wraps every frame. All vertical positions (vsync, display window, inner active window) are compared against this frame index, so they are programmed as absolute pixel counts, not as line numbers. The host works out each count beforehand: for example, a line count times the horizontal period, plus the programmed hsync skew.

Inside the display window the block either asks the pixel source for a pixel, or paints the border colour when an inner active window is enabled and the position lies outside it. A pixel that is requested but not delivered is replaced by the underflow colour. Each of hsync, vsync and data-enable can be inverted on its own. A one-cycle interrupt pulse marks the first pixel of every frame. Clearing the engine enable stops and zeroes both counters.

Top module: `lin_vtg`

## Requirements
- R1: While `cfg_engine_en` is low, both counters are held at zero. From the first clock edge that samples it low, the outputs are idle: `hsync`, `vsync` and `de` sit at their inactive level (equal to polarity bits 0, 1 and 2), and `pix_req`, `vsync_irq` and `pix_out` are zero.
- R2: The horizontal count runs from 0 to P-1, where P = `cfg_hctl[31:16]`, and then wraps. hsync is active while the horizontal count is below `cfg_hctl[15:0]`.
- R3: The frame count advances by one on every pixel clock, from 0 to `cfg_frame_period`-1, and then wraps. It does not depend on line boundaries.
- R4: vsync is active while skew <= frame count < skew + `cfg_vsync_width`, where skew is `cfg_hsync_skew`.
- R5: de is active when the horizontal count lies in [`cfg_disp_hctl[15:0]`, `cfg_disp_hctl[31:16]`] and the frame count lies in [`cfg_disp_vstart`, `cfg_disp_vend`]. Both ranges are inclusive.
- R6: The inner window is enabled horizontally by `cfg_act_hctl[31]` (start in bits 15:0, end in bits 30:16) and vertically by `cfg_act_vstart[31]` (start in bits 30:0, end in `cfg_act_vend`). Both ranges are inclusive. Inside de but outside an enabled range, `pix_out` is the border colour and `pix_req` is low. A range whose enable bit is clear does not restrict anything.
- R7: Inside de and inside the window, `pix_req` is high. `pix_out` equals `pix_data` in the same cycle if `pix_valid` is high, otherwise the underflow colour. Outside de, `pix_out` is zero.
- R8: Polarity bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts de, both while running and while idle.
- R9: `vsync_irq` is high for exactly one cycle per frame, during the cycle that shows frame count 0.
- R10: Let E0 be the first edge that samples the enable high. After E0 the outputs are still idle. After edge E(n+1) the outputs show pixel n, with horizontal count n mod P and frame count n mod the frame period. Counting restarts at zero on every enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_engine_en | input | 1 | Timing engine run enable |
| cfg_hctl | input | 2*HW | Line period [31:16], hsync width [15:0] |
| cfg_frame_period | input | FW | Frame length in pixel clocks |
| cfg_vsync_width | input | FW | vsync length in pixel clocks |
| cfg_disp_hctl | input | 2*HW | Display window horizontal end [31:16], start [15:0] |
| cfg_disp_vstart | input | FW | First frame count inside display window |
| cfg_disp_vend | input | FW | Last frame count inside display window |
| cfg_act_hctl | input | 2*HW | Inner window enable [31], end [30:16], start [15:0] |
| cfg_act_vstart | input | FW | Inner window enable [31], vertical start [30:0] |
| cfg_act_vend | input | FW | Inner window last frame count |
| cfg_border_color | input | CW | Colour outside inner window |
| cfg_underflow_color | input | CW | Colour when pixel data is missing |
| cfg_hsync_skew | input | HW | Offset of the vsync edges in the frame count |
| cfg_polarity | input | 3 | Inversion of hsync [0], vsync [1], de [2] |
| pix_valid | input | 1 | Pixel source has data this cycle |
| pix_data | input | CW | Pixel from the source |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_req | output | 1 | Request for a pixel this cycle |
| pix_out | output | CW | Output pixel colour |
| vsync_irq | output | 1 | One-cycle frame-start interrupt |

## Verification
The bench keeps the default parameters (HW = 16, FW = 32, CW = 24). It programs a small geometry: 10-pixel lines and an 80-pixel frame, a skew of 3, and a 3-pixel inner window. With these values two frame wraps, both window edges and the skewed vsync edges all fall within a few hundred cycles. A second run starts after a disable, with all three polarities inverted and the inner window switched off. This covers restart from zero, inverted idle levels and the border-free picture path. The pixel source withholds every fifth pixel, which makes the underflow colour appear inside the window.

// File: rtl/lvt_pkg.sv
package lvt_pkg;

    // Decoded, active-high timing flags for one pixel position
    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
        logic req;
        logic irq;
    } lvt_flags_t;

    localparam int unsigned LVT_NFLAGS = $bits(lvt_flags_t);

endpackage

// File: rtl/lvt_count.sv
module lvt_count #(
    parameter int unsigned HW = 16,
    parameter int unsigned FW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [HW-1:0] h_period,
    input  logic [FW-1:0] f_period,
    output logic          run,
    output logic [HW-1:0] h_cnt,
    output logic [FW-1:0] f_cnt
);

    typedef struct packed {
        logic          run;
        logic [HW-1:0] h;
        logic [FW-1:0] f;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    logic [HW:0] h_inc;
    logic [FW:0] f_inc;

    always_comb begin
        h_inc     = {1'b0, cnt_q.h} + 1'b1;
        f_inc     = {1'b0, cnt_q.f} + 1'b1;
        cnt_d     = cnt_q;
        cnt_d.run = en;
        if (!en || !cnt_q.run) begin
            cnt_d.h = '0;
            cnt_d.f = '0;
        end else begin
            cnt_d.h = (h_inc >= {1'b0, h_period}) ? '0 : h_inc[HW-1:0];
            cnt_d.f = (f_inc >= {1'b0, f_period}) ? '0 : f_inc[FW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign run   = cnt_q.run;
    assign h_cnt = cnt_q.h;
    assign f_cnt = cnt_q.f;

    // R1: counters are zero after any cycle with the engine off
    p_zero_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (h_cnt == '0 && f_cnt == '0));

    // R2: inside a line the count climbs by one per pixel clock
    p_h_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && h_cnt != '0) |-> (h_cnt == $past(h_cnt) + 1'b1));

    // R3: the frame count climbs by one per pixel clock until it wraps
    p_f_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && f_cnt != '0) |-> (f_cnt == $past(f_cnt) + 1'b1));

    // R10: a fresh run starts at position zero
    p_start_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (h_cnt == '0 && f_cnt == '0));

endmodule

// File: rtl/lvt_decode.sv
module lvt_decode
    import lvt_pkg::*;
#(
    parameter int unsigned HW = 16,
    parameter int unsigned FW = 32
) (
    input  logic [HW-1:0]   h,
    input  logic [FW-1:0]   f,
    input  logic [2*HW-1:0] hctl,
    input  logic [FW-1:0]   vsync_width,
    input  logic [2*HW-1:0] disp_hctl,
    input  logic [FW-1:0]   disp_vstart,
    input  logic [FW-1:0]   disp_vend,
    input  logic [2*HW-1:0] act_hctl,
    input  logic [FW-1:0]   act_vstart,
    input  logic [FW-1:0]   act_vend,
    input  logic [HW-1:0]   skew,
    output lvt_flags_t      flags
);

    logic [HW-1:0] hs_width, d_hlo, d_hhi, a_hlo, a_hhi;
    logic [FW-1:0] a_vlo;
    logic [FW:0]   vs_lo, vs_hi, f_ext;
    logic          a_hen, a_ven, in_dh, in_dv, ok_ah, ok_av;

    always_comb begin
        hs_width = hctl[HW-1:0];
        d_hlo    = disp_hctl[HW-1:0];
        d_hhi    = disp_hctl[2*HW-1:HW];
        a_hen    = act_hctl[2*HW-1];
        a_hlo    = act_hctl[HW-1:0];
        a_hhi    = {1'b0, act_hctl[2*HW-2:HW]};
        a_ven    = act_vstart[FW-1];
        a_vlo    = {1'b0, act_vstart[FW-2:0]};

        f_ext    = {1'b0, f};
        vs_lo    = {{(FW+1-HW){1'b0}}, skew};
        vs_hi    = vs_lo + {1'b0, vsync_width};

        in_dh    = (h >= d_hlo) && (h <= d_hhi);
        in_dv    = (f >= disp_vstart) && (f <= disp_vend);
        ok_ah    = !a_hen || ((h >= a_hlo) && (h <= a_hhi));
        ok_av    = !a_ven || ((f >= a_vlo) && (f <= act_vend));

        flags.hs  = (h < hs_width);
        flags.vs  = (f_ext >= vs_lo) && (f_ext < vs_hi);
        flags.de  = in_dh && in_dv;
        flags.req = in_dh && in_dv && ok_ah && ok_av;
        flags.irq = (f == '0);
    end

endmodule

// File: rtl/lin_vtg.sv
module lin_vtg
    import lvt_pkg::*;
#(
    parameter int unsigned HW = 16,
    parameter int unsigned FW = 32,
    parameter int unsigned CW = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_engine_en,
    input  logic [2*HW-1:0] cfg_hctl,
    input  logic [FW-1:0]   cfg_frame_period,
    input  logic [FW-1:0]   cfg_vsync_width,
    input  logic [2*HW-1:0] cfg_disp_hctl,
    input  logic [FW-1:0]   cfg_disp_vstart,
    input  logic [FW-1:0]   cfg_disp_vend,
    input  logic [2*HW-1:0] cfg_act_hctl,
    input  logic [FW-1:0]   cfg_act_vstart,
    input  logic [FW-1:0]   cfg_act_vend,
    input  logic [CW-1:0]   cfg_border_color,
    input  logic [CW-1:0]   cfg_underflow_color,
    input  logic [HW-1:0]   cfg_hsync_skew,
    input  logic [2:0]      cfg_polarity,
    input  logic            pix_valid,
    input  logic [CW-1:0]   pix_data,
    output logic            hsync,
    output logic            vsync,
    output logic            de,
    output logic            pix_req,
    output logic [CW-1:0]   pix_out,
    output logic            vsync_irq
);

    logic          run;
    logic [HW-1:0] h_cnt;
    logic [FW-1:0] f_cnt;
    lvt_flags_t    pos_flags;
    lvt_flags_t    out_d, out_q;

    lvt_count #(.HW(HW), .FW(FW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_engine_en),
        .h_period (cfg_hctl[2*HW-1:HW]),
        .f_period (cfg_frame_period),
        .run      (run),
        .h_cnt    (h_cnt),
        .f_cnt    (f_cnt)
    );

    lvt_decode #(.HW(HW), .FW(FW)) u_decode (
        .h           (h_cnt),
        .f           (f_cnt),
        .hctl        (cfg_hctl),
        .vsync_width (cfg_vsync_width),
        .disp_hctl   (cfg_disp_hctl),
        .disp_vstart (cfg_disp_vstart),
        .disp_vend   (cfg_disp_vend),
        .act_hctl    (cfg_act_hctl),
        .act_vstart  (cfg_act_vstart),
        .act_vend    (cfg_act_vend),
        .skew        (cfg_hsync_skew),
        .flags       (pos_flags)
    );

    always_comb begin
        out_d = (cfg_engine_en && run) ? pos_flags : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    always_comb begin
        hsync     = out_q.hs ^ cfg_polarity[0];
        vsync     = out_q.vs ^ cfg_polarity[1];
        de        = out_q.de ^ cfg_polarity[2];
        pix_req   = out_q.req;
        vsync_irq = out_q.irq;
        if (!out_q.de)      pix_out = '0;
        else if (!out_q.req) pix_out = cfg_border_color;
        else if (pix_valid)  pix_out = pix_data;
        else                 pix_out = cfg_underflow_color;
    end

    // R1: the cycle after the engine is off shows idle outputs
    p_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_engine_en |=> (!pix_req && !vsync_irq && pix_out == '0 &&
                            hsync == cfg_polarity[0] && vsync == cfg_polarity[1] &&
                            de == cfg_polarity[2]));

    // R6: a pixel is only requested inside the display window
    p_req_in_de_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |-> out_q.de);

    // R9: the frame interrupt never lasts two cycles on a multi-pixel frame
    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_irq && cfg_frame_period > 1 && cfg_engine_en) |=> !vsync_irq);

    // R7: the requested pixel slot carries source data or the underflow colour
    p_req_colour_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_req && !pix_valid) |-> (pix_out == cfg_underflow_color));

endmodule

// File: tb/test_lin_vtg.sv
module test_lin_vtg;

    localparam int HW = 16;
    localparam int FW = 32;
    localparam int CW = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en = 1'b0;
    logic [2*HW-1:0] hctl, disp_hctl, act_hctl;
    logic [FW-1:0]   fper, vsw, dvs, dve, avs, ave;
    logic [CW-1:0]   border, under;
    logic [HW-1:0]   skew;
    logic [2:0]      pol;
    logic            pv;
    logic [CW-1:0]   pd;
    logic            hsync, vsync, de, pix_req, vsync_irq;
    logic [CW-1:0]   pix_out;

    always #2 clk = ~clk;   // 250 MHz

    lin_vtg #(.HW(HW), .FW(FW), .CW(CW)) i_lin_vtg (
        .clk(clk), .rst_n(rst_n), .cfg_engine_en(en),
        .cfg_hctl(hctl), .cfg_frame_period(fper), .cfg_vsync_width(vsw),
        .cfg_disp_hctl(disp_hctl), .cfg_disp_vstart(dvs), .cfg_disp_vend(dve),
        .cfg_act_hctl(act_hctl), .cfg_act_vstart(avs), .cfg_act_vend(ave),
        .cfg_border_color(border), .cfg_underflow_color(under),
        .cfg_hsync_skew(skew), .cfg_polarity(pol),
        .pix_valid(pv), .pix_data(pd),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_req(pix_req),
        .pix_out(pix_out), .vsync_irq(vsync_irq)
    );

    typedef struct {
        bit            hs, vs, de, req, irq;
        logic [CW-1:0] pix;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // Reference model, written from the requirements
    function automatic exp_t model(int n);
        exp_t e;
        int h, f, hp, hw_, dhl, dhh, ahl, ahh, avl;
        bit ah_ok, av_ok;
        hp  = int'(hctl[31:16]);
        hw_ = int'(hctl[15:0]);
        h   = n % hp;
        f   = n % int'(fper);
        dhl = int'(disp_hctl[15:0]);
        dhh = int'(disp_hctl[31:16]);
        ahl = int'(act_hctl[15:0]);
        ahh = int'(act_hctl[30:16]);
        avl = int'(avs[30:0]);
        ah_ok = !act_hctl[31] || (h >= ahl && h <= ahh);
        av_ok = !avs[31] || (f >= avl && f <= int'(ave));
        e.hs  = (h < hw_);
        e.vs  = (f >= int'(skew)) && (f < int'(skew) + int'(vsw));
        e.de  = (h >= dhl && h <= dhh) && (f >= int'(dvs) && f <= int'(dve));
        e.req = e.de && ah_ok && av_ok;
        e.irq = (f == 0);
        if (!e.de)       e.pix = '0;
        else if (!e.req) e.pix = border;
        else if (pv)     e.pix = pd;
        else             e.pix = under;
        return e;
    endfunction

    // Driver: one pixel clock, then queue what the outputs must show
    task automatic step_pixel(int n);
        @(posedge clk); #1;
        pv = (n % 5) != 4;
        pd = 24'h100000 + CW'(n);
        exp_q.push_back(model(n));
    endtask

    task automatic step_idle();
        exp_t e;
        @(posedge clk); #1;
        e.hs = 0; e.vs = 0; e.de = 0; e.req = 0; e.irq = 0; e.pix = '0;
        exp_q.push_back(e);
    endtask

    // Monitor: compare away from the active edge; polarity applied here (R8)
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check("R2/R8",  "hsync",     32'(hsync),     32'(e.hs ^ pol[0]));
            check("R3/R4",  "vsync",     32'(vsync),     32'(e.vs ^ pol[1]));
            check("R5/R8",  "de",        32'(de),        32'(e.de ^ pol[2]));
            check("R6",     "pix_req",   32'(pix_req),   32'(e.req));
            check("R7",     "pix_out",   32'(pix_out),   32'(e.pix));
            check("R9/R10", "vsync_irq", 32'(vsync_irq), 32'(e.irq));
        end
    end

    initial begin
        hctl      = {16'd10, 16'd2};
        fper      = 32'd80;
        vsw       = 32'd20;
        skew      = 16'd3;
        disp_hctl = {16'd7, 16'd3};
        dvs       = 32'd33;
        dve       = 32'd62;
        act_hctl  = {1'b1, 15'd6, 16'd4};
        avs       = 32'h8000_002B;
        ave       = 32'd52;
        border    = 24'hB0B0B0;
        under     = 24'hFF0000;
        pol       = 3'b000;
        pv        = 1'b0;
        pd        = '0;

        // R1: reset state
        @(negedge clk);
        check("R1", "reset hsync",   32'(hsync),     32'(0));
        check("R1", "reset vsync",   32'(vsync),     32'(0));
        check("R1", "reset de",      32'(de),        32'(0));
        check("R1", "reset pix_req", 32'(pix_req),   32'(0));
        check("R1", "reset irq",     32'(vsync_irq), 32'(0));
        check("R1", "reset pix_out", 32'(pix_out),   32'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // Idle with engine off (R1)
        for (int k = 0; k < 3; k++) step_idle();

        // First run: inner window on, normal polarity (R2..R7, R9, R10)
        en = 1'b1;
        step_idle();                       // edge E0 still idle
        for (int n = 0; n < 170; n++) step_pixel(n);

        // Disable mid-frame (R1), then invert all polarities while idle (R8)
        en = 1'b0;
        step_idle();
        pol = 3'b111;
        for (int k = 0; k < 3; k++) step_idle();

        // Second run: inner window off, restart from zero (R6, R8, R10)
        act_hctl = {1'b0, 15'd6, 16'd4};
        avs      = 32'h0000_002B;
        step_idle();
        en = 1'b1;
        step_idle();
        for (int n = 0; n < 90; n++) step_pixel(n);

        @(negedge clk); @(negedge clk);
        done = 1'b1;
    end

    // Watchdog
    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule